// File: doc/BRIEF.md
# Wrap-Counting Accumulator with Widened Result

This block keeps a running sum of ACC_W bits. It adds one operand to that sum on every cycle that the accumulate enable is high. A mode pin chooses between unsigned and two's-complement arithmetic. The operand is OP_W bits wide and is widened to the sum width before the add. In unsigned mode the new upper bits are filled with zeros. In signed mode they are copies of the operand's top bit.

When an add crosses the wrap boundary of the sum, the block raises a pulse that lasts one cycle. In unsigned mode that boundary lies between the largest value and zero. In signed mode it lies between the most positive and the most negative value. A small counter inside the block counts these wrap events. The block places that count above the sum, so the result can be read as a wider number of ACC_W+EXT_W bits.

The operand enters on a plain enable with no back-pressure, and the block accepts an operand on every enabled cycle. The sum, the pulse and the wide result all come from registers. They change on the clock edge that consumes an operand.

Top module: `acc_ovx_top`

## Requirements
- R1: In unsigned mode (mode pin 0), the operand is zero-extended. An OP_W=9 operand of 0x1FA adds 506 to the sum.
- R2: In signed mode (mode pin 1), the operand is sign-extended from bit OP_W-1. An OP_W=9 operand of 0x1FA adds -6 to the sum.
- R3: On a clock edge where enable is high and clear is low, the sum output takes the value (previous sum + extended operand) mod 2^ACC_W. The new value shows from that edge on.
- R4: On a clock edge where enable and clear are both low, the sum and the wide result keep their values and the wrap pulse is low after that edge.
- R5: In unsigned mode, the wrap pulse is high for the cycle after an add whose true result is 2^ACC_W or more. In that case the new sum is smaller than the old sum.
- R6: In signed mode, the wrap pulse is high for the cycle after an add in which both inputs had the same sign bit and the result has the other sign bit.
- R7: The wrap pulse lasts exactly one cycle for each wrapping add. It is low after any add that does not wrap, even right after a wrap.
- R8: The wrap counter adds 1 on each unsigned wrap and on each signed wrap in the positive direction. It subtracts 1 on each signed wrap in the negative direction. It does not change on any other edge.
- R9: The wide output equals the true running total mod 2^(ACC_W+EXT_W). In unsigned mode that is {counter, sum}. In signed mode it is the sign-extended sum plus counter×2^ACC_W.
- R10: A synchronous clear takes priority over enable. It sets the sum, the counter and the wide output to zero, and the wrap pulse is low after it.
- R11: While reset is high, the sum, the wide output and the wrap pulse are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_en | input | 1 | Accumulate the operand on this edge |
| acc_clr | input | 1 | Synchronous clear of the sum and the counter; overrides acc_en |
| signed_mode | input | 1 | 0 selects unsigned arithmetic, 1 selects two's-complement arithmetic |
| operand | input | OP_W | Addend, widened according to signed_mode |
| sum_o | output | ACC_W | Running sum |
| wrap_pulse_o | output | 1 | One-cycle pulse after a wrapping add |
| wide_o | output | ACC_W+EXT_W | Wrap counter combined with the sum into a wider result |

## Verification
The unsigned runs add large operands such as 511 and 0x1FA until the sum passes 2^ACC_W. These show whether zero-extension is applied and whether the carry produces the pulse and the count going up. The signed runs use the same bit pattern 0x1FA, which separates sign-extension from zero-extension. They then climb with +255 to produce wraps in the positive direction and fall with -256 to produce wraps in the negative direction, which shows whether the counter steps the right way. Mixed-sign adds near the boundaries, idle cycles, and a clear issued on an add that would wrap show whether the pulse is suppressed and whether the value is held. At every step the wide output is compared with the true total kept by the bench.

// File: rtl/acc_ovx_pkg.sv
package acc_ovx_pkg;

  typedef enum logic {
    ARITH_UNSIGNED = 1'b0,
    ARITH_SIGNED   = 1'b1
  } arith_e;

  typedef enum logic [1:0] {
    WRAP_NONE = 2'd0,
    WRAP_UP   = 2'd1,
    WRAP_DOWN = 2'd2
  } wrap_e;

endpackage

// File: rtl/acc_opext.sv
module acc_opext
  import acc_ovx_pkg::*;
#(
  parameter int OP_W  = 9,
  parameter int ACC_W = 18
) (
  input  arith_e             mode,
  input  logic [OP_W-1:0]    op,
  output logic [ACC_W-1:0]   op_wide
);
  localparam int PAD_W = ACC_W - OP_W;

  logic fill_bit;

  // In signed mode the fill bit copies the operand's top bit; in unsigned mode it is zero.
  assign fill_bit = (mode == ARITH_SIGNED) ? op[OP_W-1] : 1'b0;

  generate
    if (PAD_W > 0) begin : g_pad
      assign op_wide = {{PAD_W{fill_bit}}, op};
    end else begin : g_nopad
      assign op_wide = op[ACC_W-1:0];
    end
  endgenerate

endmodule

// File: rtl/acc_wrapdet.sv
module acc_wrapdet
  import acc_ovx_pkg::*;
#(
  parameter int ACC_W = 18
) (
  input  arith_e             mode,
  input  logic [ACC_W-1:0]   acc,
  input  logic [ACC_W-1:0]   addend,
  output logic [ACC_W-1:0]   sum,
  output wrap_e              kind
);
  localparam int MSB = ACC_W - 1;

  logic [ACC_W:0] full;
  logic           carry;
  logic           same_sign;
  logic           sign_flip;

  assign full      = {1'b0, acc} + {1'b0, addend};
  assign sum       = full[MSB:0];
  assign carry     = full[ACC_W];
  assign same_sign = (acc[MSB] == addend[MSB]);
  assign sign_flip = (sum[MSB] != acc[MSB]);

  always_comb begin
    kind = WRAP_NONE;
    if (mode == ARITH_SIGNED) begin
      // A signed add can only wrap when both inputs have the same sign.
      if (same_sign && sign_flip) begin
        kind = acc[MSB] ? WRAP_DOWN : WRAP_UP;
      end
    end else if (carry) begin
      kind = WRAP_UP;
    end
  end

endmodule

// File: rtl/acc_extcnt.sv
module acc_extcnt
  import acc_ovx_pkg::*;
#(
  parameter int EXT_W = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               step_en,
  input  wrap_e              kind,
  output logic [EXT_W-1:0]   cnt_q
);
  localparam logic [EXT_W-1:0] ONE = EXT_W'(1);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (step_en) begin
      unique case (kind)
        WRAP_UP:   cnt_q <= cnt_q + ONE;
        WRAP_DOWN: cnt_q <= cnt_q - ONE;
        default:   cnt_q <= cnt_q;
      endcase
    end
  end

endmodule

// File: rtl/acc_ovx_top.sv
module acc_ovx_top
  import acc_ovx_pkg::*;
#(
  parameter int OP_W  = 9,
  parameter int ACC_W = 18,
  parameter int EXT_W = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     acc_en,
  input  logic                     acc_clr,
  input  logic                     signed_mode,
  input  logic [OP_W-1:0]          operand,
  output logic [ACC_W-1:0]         sum_o,
  output logic                     wrap_pulse_o,
  output logic [ACC_W+EXT_W-1:0]   wide_o
);
  localparam int WIDE_W = ACC_W + EXT_W;
  localparam int MSB    = ACC_W - 1;

  arith_e              mode;
  logic [ACC_W-1:0]    op_wide;
  logic [ACC_W-1:0]    next_sum;
  wrap_e               kind;
  logic                take;
  logic [ACC_W-1:0]    acc_q;
  logic                pulse_q;
  logic [EXT_W-1:0]    cnt_q;

  assign mode = signed_mode ? ARITH_SIGNED : ARITH_UNSIGNED;
  assign take = acc_en && !acc_clr;

  acc_opext #(.OP_W(OP_W), .ACC_W(ACC_W)) u_opext (
    .mode    (mode),
    .op      (operand),
    .op_wide (op_wide)
  );

  acc_wrapdet #(.ACC_W(ACC_W)) u_wrapdet (
    .mode   (mode),
    .acc    (acc_q),
    .addend (op_wide),
    .sum    (next_sum),
    .kind   (kind)
  );

  acc_extcnt #(.EXT_W(EXT_W)) u_extcnt (
    .clk     (clk),
    .rst     (rst),
    .clr     (acc_clr),
    .step_en (take),
    .kind    (kind),
    .cnt_q   (cnt_q)
  );

  always_ff @(posedge clk) begin
    if (rst || acc_clr) begin
      acc_q   <= '0;
      pulse_q <= 1'b0;
    end else if (take) begin
      acc_q   <= next_sum;
      pulse_q <= (kind != WRAP_NONE);
    end else begin
      pulse_q <= 1'b0;
    end
  end

  // The counter is the upper part of the wide result. In signed mode it is added to the sign-extended sum.
  always_comb begin
    if (signed_mode) begin
      wide_o = {{EXT_W{acc_q[MSB]}}, acc_q} + {cnt_q, {ACC_W{1'b0}}};
    end else begin
      wide_o = {cnt_q, acc_q};
    end
  end

  assign sum_o        = acc_q;
  assign wrap_pulse_o = pulse_q;

endmodule

// File: rtl/acc_ovx_chk.sv
module acc_ovx_chk #(
  parameter int OP_W  = 9,
  parameter int ACC_W = 18,
  parameter int EXT_W = 6
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    acc_en,
  input logic                    acc_clr,
  input logic                    signed_mode,
  input logic [OP_W-1:0]         operand,
  input logic [ACC_W-1:0]        sum_o,
  input logic                    wrap_pulse_o,
  input logic [ACC_W+EXT_W-1:0]  wide_o,
  input logic [EXT_W-1:0]        cnt_q
);
  localparam int MSB = ACC_W - 1;

  p_idle_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!acc_en && !acc_clr) |=> ($stable(sum_o) && $stable(wide_o) && !wrap_pulse_o));

  p_clear_r10: assert property (@(posedge clk) disable iff (rst)
    acc_clr |=> (sum_o == '0 && wide_o == '0 && !wrap_pulse_o));

  p_uwrap_r5: assert property (@(posedge clk) disable iff (rst)
    (acc_en && !acc_clr && !signed_mode) |=> (wrap_pulse_o == (sum_o < $past(sum_o))));

  p_swrap_r6: assert property (@(posedge clk) disable iff (rst)
    (acc_en && !acc_clr && signed_mode) |=>
      (wrap_pulse_o == (($past(sum_o[MSB]) == $past(operand[OP_W-1])) &&
                        (sum_o[MSB] != $past(sum_o[MSB])))));

  p_cnt_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !acc_clr |=> (wrap_pulse_o || cnt_q == $past(cnt_q)));

  p_cnt_up_r8: assert property (@(posedge clk) disable iff (rst)
    (acc_en && !acc_clr && !signed_mode) |=> (!wrap_pulse_o || cnt_q == EXT_W'($past(cnt_q) + 1'b1)));

  p_pulse_cause_r7: assert property (@(posedge clk) disable iff (rst)
    wrap_pulse_o |-> ($past(acc_en) && !$past(acc_clr)));

endmodule

bind acc_ovx_top acc_ovx_chk #(.OP_W(OP_W), .ACC_W(ACC_W), .EXT_W(EXT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .acc_en       (acc_en),
  .acc_clr      (acc_clr),
  .signed_mode  (signed_mode),
  .operand      (operand),
  .sum_o        (sum_o),
  .wrap_pulse_o (wrap_pulse_o),
  .wide_o       (wide_o),
  .cnt_q        (cnt_q)
);

// File: tb/acc_ovx_top_test.sv
`timescale 1ns/1ps
module acc_ovx_top_test;
  localparam int OP_W  = 9;
  localparam int ACC_W = 10;
  localparam int EXT_W = 4;
  localparam int WIDE_W = ACC_W + EXT_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic acc_en = 1'b0;
  logic acc_clr = 1'b0;
  logic signed_mode = 1'b0;
  logic [OP_W-1:0] operand = '0;
  logic [ACC_W-1:0] sum_o;
  logic wrap_pulse_o;
  logic [WIDE_W-1:0] wide_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  longint total = 0;

  logic [ACC_W-1:0]  q_sum[$];
  logic              q_pulse[$];
  logic [WIDE_W-1:0] q_wide[$];
  string             q_tag[$];

  always #4 clk = ~clk;

  acc_ovx_top #(.OP_W(OP_W), .ACC_W(ACC_W), .EXT_W(EXT_W)) uut (
    .clk(clk), .rst(rst), .acc_en(acc_en), .acc_clr(acc_clr),
    .signed_mode(signed_mode), .operand(operand),
    .sum_o(sum_o), .wrap_pulse_o(wrap_pulse_o), .wide_o(wide_o)
  );

  // Driver: applies one cycle of stimulus and queues the result the requirements predict.
  task automatic step(input logic [OP_W-1:0] op, input logic md, input logic en,
                      input logic clr, input string tag);
    longint prev_u, prev_s, add, res;
    logic   exp_pulse;
    @(negedge clk);
    operand = op; signed_mode = md; acc_en = en; acc_clr = clr;
    exp_pulse = 1'b0;
    prev_u = total & ((64'sd1 <<< ACC_W) - 1);
    if (clr) begin
      total = 0;
    end else if (en) begin
      if (md) begin
        add    = op[OP_W-1] ? longint'(op) - (64'sd1 <<< OP_W) : longint'(op);
        prev_s = (prev_u >= (64'sd1 <<< (ACC_W-1))) ? prev_u - (64'sd1 <<< ACC_W) : prev_u;
        res    = prev_s + add;
        exp_pulse = (res >= (64'sd1 <<< (ACC_W-1))) || (res < -(64'sd1 <<< (ACC_W-1)));
      end else begin
        add = longint'(op);
        res = prev_u + add;
        exp_pulse = (res >= (64'sd1 <<< ACC_W));
      end
      total = total + add;
    end
    @(posedge clk);
    #1;
    q_sum.push_back(ACC_W'(total));
    q_pulse.push_back(exp_pulse);
    q_wide.push_back(WIDE_W'(total));
    q_tag.push_back(tag);
  endtask

  // Monitor: compares outputs with the queued expectations at the falling edge.
  always @(negedge clk) begin
    if (q_sum.size() > 0) begin
      logic [ACC_W-1:0]  es;
      logic              ep;
      logic [WIDE_W-1:0] ew;
      string             tg;
      es = q_sum.pop_front(); ep = q_pulse.pop_front();
      ew = q_wide.pop_front(); tg = q_tag.pop_front();
      checks++;
      if (sum_o !== es || wrap_pulse_o !== ep || wide_o !== ew) begin
        errors++;
        $display("FAIL %s: sum=%0d pulse=%0b wide=%0h, expected sum=%0d pulse=%0b wide=%0h",
                 tg, sum_o, wrap_pulse_o, wide_o, es, ep, ew);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;  // R11 reset state
    if (sum_o !== '0 || wrap_pulse_o !== 1'b0 || wide_o !== '0) begin
      errors++;
      $display("FAIL R11: sum=%0d pulse=%0b wide=%0h, expected all zero", sum_o, wrap_pulse_o, wide_o);
    end
    rst = 1'b0;

    // Unsigned: zero-extension, accumulation, idle hold
    step(9'h1FA, 1'b0, 1'b1, 1'b0, "R1");
    step(9'd6,   1'b0, 1'b1, 1'b0, "R3");
    step(9'd77,  1'b0, 1'b0, 1'b0, "R4");
    step(9'd77,  1'b0, 1'b0, 1'b0, "R4");
    step(9'd511, 1'b0, 1'b1, 1'b0, "R3");
    step(9'd1,   1'b0, 1'b1, 1'b0, "R5");   // 1024 wraps to 0
    step(9'd5,   1'b0, 1'b1, 1'b0, "R7");
    step(9'd9,   1'b0, 1'b0, 1'b0, "R4");
    for (int i = 0; i < 20; i++) step(9'd511, 1'b0, 1'b1, 1'b0, "R8");
    step(9'd0, 1'b0, 1'b0, 1'b0, "R9");

    // Clear beats enable
    step(9'd511, 1'b0, 1'b1, 1'b1, "R10");

    // Signed: sign-extension, positive and negative wraps
    step(9'h1FA, 1'b1, 1'b1, 1'b0, "R2");
    for (int i = 0; i < 12; i++) step(9'd255, 1'b1, 1'b1, 1'b0, "R6");
    step(9'd3, 1'b1, 1'b0, 1'b0, "R4");
    for (int i = 0; i < 30; i++) step(9'h100, 1'b1, 1'b1, 1'b0, "R8");
    step(9'd200, 1'b1, 1'b1, 1'b0, "R9");
    step(9'h1F0, 1'b1, 1'b1, 1'b0, "R6");

    // Clear on an add that would wrap: no pulse
    step(9'd0, 1'b1, 1'b0, 1'b1, "R10");
    step(9'd255, 1'b1, 1'b1, 1'b0, "R3");
    step(9'd255, 1'b1, 1'b1, 1'b0, "R3");
    step(9'd255, 1'b1, 1'b1, 1'b1, "R10");
    step(9'd255, 1'b1, 1'b1, 1'b0, "R7");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule